// File: doc/BRIEF.md
# Serial Transmit Flow-Control Gate

This block sits, one instance per serial port, between a byte source and a UART transmitter. It holds back the next character while any enabled flow-control condition forbids it. Those conditions are a low modem status line, an XOFF received from the far end, or a halt after the gate itself has sent XOFF. The gate never withdraws a character once the transmitter has taken it, so stops happen only between characters.

The gate also throttles the far end. A receive almost-full flag can drop RTS, drop DTR, or cause the gate to slip an XOFF character into the transmit stream, with an XON following when the flag falls. A half-duplex option instead drives RTS around each burst of transmission. The received byte stream can be marked for discard while DSR is low.

Configuration arrives as write strobes from a command parser outside this block. A transmit mask and a receive mask choose which flow types are active, and several may be active together. Two further strobes reprogram the XON and XOFF characters.

Top module: `serial_tx_flow_gate`

## Requirements
- R1: Transmit mask bits 0, 1 and 2 block source data while synchronised CTS, DSR or DCD respectively is low. Each modem input passes through two flip-flops, so a change at the input alters the gate decision after the second rising edge.
- R2: When transmit mask bit 3 is set, a received character equal to the XOFF character blocks source data from the following cycle. A received XON character releases it. If the received character matches both, XOFF wins. Clearing bit 3 releases the block.
- R3: When receive mask bit 3 is set, a rising almost-full flag queues an XOFF and a falling flag queues an XON, and the newer edge replaces any queued one. A queued character is offered on tx_byte ahead of source data, is not subject to modem or received-XOFF gating, and src_rdy stays low while it waits.
- R4: With transmit mask bit 4 clear, source data halts once the gate has sent an XOFF, until the gate sends an XON. Setting bit 4 removes that halt.
- R5: With transmit mask bit 5 set, rts_o is registered high one cycle after any of these holds: source data is valid, a character is queued, or tx_active is high. It falls one cycle after none of them holds. Nothing is offered to the transmitter while rts_o is low.
- R6: Outside the half-duplex mode, receive mask bit 0 drives rts_o low, and receive mask bit 1 drives dtr_o low, one cycle after the almost-full flag is seen high. Each returns high one cycle after the flag is seen low.
- R7: When receive mask bit 2 is set, rx_char_keep is low for a received character unless synchronised DSR is high. With the bit clear, rx_char_keep follows rx_char_vld.
- R8: The XON and XOFF characters reset to 0x11 and 0x13. Each can be rewritten through its own strobe, and the new value is used from the next cycle.
- R9: After reset both masks are zero, so source data passes straight through with no flow control. No character is queued, and rts_o and dtr_o are high.
- R10: A source byte moves only when tx_vld and tx_rdy are both high with no queued character, and src_rdy is high exactly then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_txmask_we | input | 1 | Write strobe for the transmit flow mask |
| cfg_txmask | input | 6 | New transmit flow mask |
| cfg_rxmask_we | input | 1 | Write strobe for the receive flow mask |
| cfg_rxmask | input | 4 | New receive flow mask |
| cfg_xon_we | input | 1 | Write strobe for the XON character |
| cfg_xoff_we | input | 1 | Write strobe for the XOFF character |
| cfg_char | input | CHAR_W | Character value for the XON/XOFF strobes |
| cts_i | input | 1 | Clear-to-send level, asynchronous, high = asserted |
| dsr_i | input | 1 | Data-set-ready level, asynchronous, high = asserted |
| dcd_i | input | 1 | Carrier-detect level, asynchronous, high = asserted |
| rx_char_vld | input | 1 | A received character is present this cycle |
| rx_char | input | CHAR_W | The received character |
| rx_char_keep | output | 1 | The received character should be kept |
| rx_almost_full | input | 1 | Receive buffer is nearly full |
| src_vld | input | 1 | Source has a byte to transmit |
| src_byte | input | CHAR_W | Source byte |
| src_rdy | output | 1 | Source byte is taken this cycle |
| tx_vld | output | 1 | A character is offered to the transmitter |
| tx_byte | output | CHAR_W | Character offered to the transmitter |
| tx_rdy | input | 1 | Transmitter takes the offered character |
| tx_active | input | 1 | Transmitter is still shifting out a character |
| rts_o | output | 1 | Request-to-send drive, high = asserted |
| dtr_o | output | 1 | Data-terminal-ready drive, high = asserted |

## Verification
The handshake outputs tx_vld, tx_byte, src_rdy and rx_char_keep respond combinationally to the current inputs and to state updated at the last edge. Configuration writes, received XON/XOFF, almost-full edges and sent characters therefore show up one cycle later, and modem inputs two cycles later. rts_o and dtr_o are registered one cycle behind their causes. The bench drives inputs on the falling edge, updates a reference model on the rising edge with exactly those delays, and compares every output shortly after each falling edge. The directed cases cover the exact turn-on and turn-off cycles: two edges for a modem line, one for a received XOFF, one for the queued XOFF and XON around an almost-full pulse.

// File: rtl/serial_tx_flow_gate.sv
module serial_tx_flow_gate #(
  parameter int CHAR_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [CHAR_W-1:0] XON_RESET = 8'h11,
  parameter logic [CHAR_W-1:0] XOFF_RESET = 8'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_txmask_we,
  input  logic [5:0]        cfg_txmask,
  input  logic              cfg_rxmask_we,
  input  logic [3:0]        cfg_rxmask,
  input  logic              cfg_xon_we,
  input  logic              cfg_xoff_we,
  input  logic [CHAR_W-1:0] cfg_char,
  input  logic              cts_i,
  input  logic              dsr_i,
  input  logic              dcd_i,
  input  logic              rx_char_vld,
  input  logic [CHAR_W-1:0] rx_char,
  output logic              rx_char_keep,
  input  logic              rx_almost_full,
  input  logic              src_vld,
  input  logic [CHAR_W-1:0] src_byte,
  output logic              src_rdy,
  output logic              tx_vld,
  output logic [CHAR_W-1:0] tx_byte,
  input  logic              tx_rdy,
  input  logic              tx_active,
  output logic              rts_o,
  output logic              dtr_o
);
  localparam int SR_W = SYNC_STAGES * 3;

  logic [SR_W-1:0]   sync_sr;
  logic [5:0]        txm_q;
  logic [3:0]        rxm_q;
  logic [CHAR_W-1:0] xon_q, xoff_q;
  logic              xoff_seen_q, self_halt_q, pend_off_q, pend_on_q;
  logic              af_q, rts_q, dtr_q;

  wire cts_s = sync_sr[SR_W-3];
  wire dsr_s = sync_sr[SR_W-2];
  wire dcd_s = sync_sr[SR_W-1];

  wire ins         = pend_off_q | pend_on_q;
  wire rts_ok      = !txm_q[5] | rts_q;
  wire modem_block = (txm_q[0] & !cts_s) | (txm_q[1] & !dsr_s) | (txm_q[2] & !dcd_s);
  wire data_ok     = !modem_block & !(txm_q[3] & xoff_seen_q) & !self_halt_q & rts_ok;
  wire ins_go      = ins & rts_ok & tx_rdy;
  wire af_rise     = rx_almost_full & !af_q;
  wire af_fall     = !rx_almost_full & af_q;

  assign tx_vld       = ins ? rts_ok : (src_vld & data_ok);
  assign tx_byte      = pend_off_q ? xoff_q : (pend_on_q ? xon_q : src_byte);
  assign src_rdy      = !ins & src_vld & data_ok & tx_rdy;
  assign rx_char_keep = rx_char_vld & (!rxm_q[2] | dsr_s);
  assign rts_o        = rts_q;
  assign dtr_o        = dtr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_sr <= '1;
    else        sync_sr <= {sync_sr[SR_W-4:0], dcd_i, dsr_i, cts_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txm_q  <= '0;
      rxm_q  <= '0;
      xon_q  <= XON_RESET;
      xoff_q <= XOFF_RESET;
    end else begin
      if (cfg_txmask_we) txm_q  <= cfg_txmask;
      if (cfg_rxmask_we) rxm_q  <= cfg_rxmask;
      if (cfg_xon_we)    xon_q  <= cfg_char;
      if (cfg_xoff_we)   xoff_q <= cfg_char;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xoff_seen_q <= 1'b0;
    else if (!txm_q[3]) xoff_seen_q <= 1'b0;
    else if (rx_char_vld && rx_char == xoff_q) xoff_seen_q <= 1'b1;
    else if (rx_char_vld && rx_char == xon_q) xoff_seen_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) self_halt_q <= 1'b0;
    else if (txm_q[4]) self_halt_q <= 1'b0;
    else if (ins_go) self_halt_q <= pend_off_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_off_q <= 1'b0;
      pend_on_q  <= 1'b0;
      af_q       <= 1'b0;
    end else begin
      af_q <= rx_almost_full;
      if (ins_go) begin
        if (pend_off_q) pend_off_q <= 1'b0;
        else            pend_on_q  <= 1'b0;
      end
      if (rxm_q[3] && af_rise) begin
        pend_off_q <= 1'b1;
        pend_on_q  <= 1'b0;
      end else if (rxm_q[3] && af_fall) begin
        pend_on_q  <= 1'b1;
        pend_off_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_q <= 1'b1;
      dtr_q <= 1'b1;
    end else begin
      rts_q <= txm_q[5] ? (src_vld | ins | tx_active) : !(rxm_q[0] & rx_almost_full);
      dtr_q <= !(rxm_q[1] & rx_almost_full);
    end
  end

  p_modem_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (txm_q[0] && !cts_s) |-> !src_rdy);
  p_xoff_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (txm_q[3] && xoff_seen_q) |-> !src_rdy);
  p_one_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pend_off_q, pend_on_q}) <= 1);
  p_insert_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ins |-> !src_rdy);
  p_self_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_go && pend_off_q && !txm_q[4]) |=> !src_rdy);
  p_toggle_rts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (txm_q[5] && !rts_o) |-> !tx_vld);
  p_dtr_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rxm_q[1] && rx_almost_full) |=> !dtr_o);
  p_handshake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    src_rdy |-> (tx_vld && tx_rdy));
endmodule

// File: tb/serial_tx_flow_gate_bench.sv
`timescale 1ns/1ps
module serial_tx_flow_gate_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic cfg_txmask_we, cfg_rxmask_we, cfg_xon_we, cfg_xoff_we;
  logic [5:0] cfg_txmask;
  logic [3:0] cfg_rxmask;
  logic [7:0] cfg_char, rx_char, src_byte, tx_byte;
  logic cts_i, dsr_i, dcd_i, rx_char_vld, rx_char_keep, rx_almost_full;
  logic src_vld, src_rdy, tx_vld, tx_rdy, tx_active, rts_o, dtr_o;

  serial_tx_flow_gate u_serial_tx_flow_gate (.*);

  int nvec = 0, nbad = 0;

  logic [5:0] m_txm; logic [3:0] m_rxm; logic [7:0] m_xon, m_xoff;
  logic [2:0] m_s1, m_s2;
  logic m_xs, m_halt, m_poff, m_pon, m_af, m_rts, m_dtr;
  logic e_tx_vld, e_src_rdy, e_keep, e_ins_go, e_ins; logic [7:0] e_byte;

  function void model_reset();
    m_txm = 0; m_rxm = 0; m_xon = 8'h11; m_xoff = 8'h13;
    m_s1 = 3'b111; m_s2 = 3'b111;
    m_xs = 0; m_halt = 0; m_poff = 0; m_pon = 0; m_af = 0; m_rts = 1; m_dtr = 1;
  endfunction

  function void eval();
    logic ok, rok;
    rok = !m_txm[5] || m_rts;
    ok = !(m_txm[0] && !m_s2[0]) && !(m_txm[1] && !m_s2[1]) && !(m_txm[2] && !m_s2[2])
         && !(m_txm[3] && m_xs) && !m_halt && rok;
    e_ins = m_poff || m_pon;
    e_tx_vld = e_ins ? rok : (src_vld && ok);
    e_byte = m_poff ? m_xoff : (m_pon ? m_xon : src_byte);
    e_src_rdy = !e_ins && src_vld && ok && tx_rdy;
    e_ins_go = e_ins && rok && tx_rdy;
    e_keep = rx_char_vld && (!m_rxm[2] || m_s2[1]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      logic n_xs, n_halt, n_poff, n_pon;
      eval();
      if (!m_txm[3]) n_xs = 0;
      else if (rx_char_vld && rx_char == m_xoff) n_xs = 1;
      else if (rx_char_vld && rx_char == m_xon) n_xs = 0;
      else n_xs = m_xs;
      n_halt = m_txm[4] ? 1'b0 : (e_ins_go ? m_poff : m_halt);
      n_poff = m_poff; n_pon = m_pon;
      if (e_ins_go) begin if (m_poff) n_poff = 0; else n_pon = 0; end
      if (m_rxm[3] && rx_almost_full && !m_af) begin n_poff = 1; n_pon = 0; end
      else if (m_rxm[3] && !rx_almost_full && m_af) begin n_pon = 1; n_poff = 0; end
      m_rts = m_txm[5] ? (src_vld || e_ins || tx_active) : !(m_rxm[0] && rx_almost_full);
      m_dtr = !(m_rxm[1] && rx_almost_full);
      m_af = rx_almost_full;
      m_xs = n_xs; m_halt = n_halt; m_poff = n_poff; m_pon = n_pon;
      m_s2 = m_s1; m_s1 = {dcd_i, dsr_i, cts_i};
      if (cfg_txmask_we) m_txm = cfg_txmask;
      if (cfg_rxmask_we) m_rxm = cfg_rxmask;
      if (cfg_xon_we) m_xon = cfg_char;
      if (cfg_xoff_we) m_xoff = cfg_char;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    #1;
    eval();
    chk("R10 tx_vld", {7'd0, tx_vld}, {7'd0, e_tx_vld});
    chk("R10 src_rdy", {7'd0, src_rdy}, {7'd0, e_src_rdy});
    if (e_tx_vld) chk("R3 tx_byte", tx_byte, e_byte);
    chk("R7 rx_char_keep", {7'd0, rx_char_keep}, {7'd0, e_keep});
    chk(m_txm[5] ? "R5 rts_o" : "R6 rts_o", {7'd0, rts_o}, {7'd0, m_rts});
    chk("R6 dtr_o", {7'd0, dtr_o}, {7'd0, m_dtr});
  endtask

  task automatic next();
    @(negedge clk);
    cfg_txmask_we = 0; cfg_rxmask_we = 0; cfg_xon_we = 0; cfg_xoff_we = 0;
    rx_char_vld = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    #200000;
    nbad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rst_n = 0;
    cfg_txmask_we = 0; cfg_rxmask_we = 0; cfg_xon_we = 0; cfg_xoff_we = 0;
    cfg_txmask = 0; cfg_rxmask = 0; cfg_char = 0;
    cts_i = 1; dsr_i = 1; dcd_i = 1; rx_char_vld = 0; rx_char = 0; rx_almost_full = 0;
    src_vld = 0; src_byte = 0; tx_rdy = 1; tx_active = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R9: reset state, pass-through
    src_vld = 1; src_byte = 8'hA5;
    compare();
    chk("R9 rts_o after reset", {7'd0, rts_o}, 8'd1);
    chk("R9 dtr_o after reset", {7'd0, dtr_o}, 8'd1);
    chk("R9 pass-through byte", tx_byte, 8'hA5);
    chk("R9 pass-through ready", {7'd0, src_rdy}, 8'd1);

    // R2 with default R8 characters
    next(); cfg_txmask_we = 1; cfg_txmask = 6'h08; compare();
    next(); rx_char_vld = 1; rx_char = 8'h13; compare();
    chk("R2 no block before edge", {7'd0, src_rdy}, 8'd1);
    next(); compare();
    chk("R2 blocked after XOFF 0x13", {7'd0, src_rdy}, 8'd0);
    next(); rx_char_vld = 1; rx_char = 8'h11; compare();
    next(); compare();
    chk("R2 released by XON 0x11", {7'd0, src_rdy}, 8'd1);

    // R1: CTS gating through two-stage sync
    next(); cfg_txmask_we = 1; cfg_txmask = 6'h01; cts_i = 0; compare();
    next(); compare();
    chk("R1 one edge after CTS low", {7'd0, src_rdy}, 8'd1);
    next(); compare();
    chk("R1 two edges after CTS low", {7'd0, src_rdy}, 8'd0);
    next(); cts_i = 1; compare();
    next(); compare();
    next(); compare();
    chk("R1 released after CTS high", {7'd0, src_rdy}, 8'd1);

    // R3/R4: inserted XOFF then XON, self halt
    next(); cfg_txmask_we = 1; cfg_txmask = 6'h00; cfg_rxmask_we = 1; cfg_rxmask = 4'h8; compare();
    next(); rx_almost_full = 1; tx_rdy = 0; compare();
    next(); compare();
    chk("R3 XOFF queued", tx_byte, 8'h13);
    chk("R3 source held", {7'd0, src_rdy}, 8'd0);
    next(); tx_rdy = 1; compare();
    next(); compare();
    chk("R4 halted after own XOFF", {7'd0, tx_vld}, 8'd0);
    next(); rx_almost_full = 0; tx_rdy = 0; compare();
    next(); compare();
    chk("R3 XON queued", tx_byte, 8'h11);
    next(); tx_rdy = 1; compare();
    next(); compare();
    chk("R4 resumed after own XON", {7'd0, src_rdy}, 8'd1);

    // R8: reprogrammed XOFF character
    next(); cfg_xoff_we = 1; cfg_char = 8'h55; cfg_txmask_we = 1; cfg_txmask = 6'h08; compare();
    next(); rx_char_vld = 1; rx_char = 8'h55; compare();
    next(); compare();
    chk("R8 new XOFF 0x55 blocks", {7'd0, src_rdy}, 8'd0);
    next(); rx_char_vld = 1; rx_char = 8'h11; compare();

    // Random phase
    for (int i = 0; i < 6000; i++) begin
      next();
      src_vld = ($urandom % 4) != 0; src_byte = 8'($urandom);
      tx_rdy = ($urandom % 3) != 0; tx_active = ($urandom % 4) == 0;
      if ($urandom % 8 == 0) cts_i = ~cts_i;
      if ($urandom % 8 == 0) dsr_i = ~dsr_i;
      if ($urandom % 8 == 0) dcd_i = ~dcd_i;
      if ($urandom % 10 == 0) rx_almost_full = ~rx_almost_full;
      rx_char_vld = ($urandom % 3) == 0;
      case ($urandom % 4)
        0: rx_char = m_xon;
        1: rx_char = m_xoff;
        default: rx_char = 8'($urandom);
      endcase
      if ($urandom % 40 == 0) begin cfg_txmask_we = 1; cfg_txmask = 6'($urandom); end
      if ($urandom % 40 == 0) begin cfg_rxmask_we = 1; cfg_rxmask = 4'($urandom); end
      if ($urandom % 200 == 0) begin cfg_xon_we = 1; cfg_char = 8'($urandom); end
      else if ($urandom % 200 == 0) begin cfg_xoff_we = 1; cfg_char = 8'($urandom); end
      compare();
    end
    finish_run();
  end
endmodule